// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls thirteen general-purpose pins through a byte-wide register bus. The pins fall into three banks of seven, four and two. Each pin has two registers. The output-control register sets direction, drive type, pull resistor settings and the driven value. The input-control register selects which edges raise an interrupt, and its low bit returns the pin's synchronized level. The pad drive and pull settings leave the block as plain control outputs for a pad ring.

Every pin input passes through a two-stage synchronizer, and then an edge detector compares it against its previous value. An edge accepted by the pin's detection mode sets a pending bit. The pending bits form two groups: pins 0 to 6 are in group 0, and pins 7 to 12 are in group 1. Each group has a status register and a mask register. One interrupt line goes high while any pending bit is not masked.

Host software writes ones to a status register to clear the pending bits it has serviced. It masks or unmasks pins through the mask registers. Register writes and pad changes take effect on the rising clock edge. Reads are combinational from the address.

Top module: `edge_gpio_ctrl`

## Requirements
- R1: After reset, every output-control and input-control register reads 0. Both status registers read 0. The mask registers read 0x7F (group 0) and 0x3F (group 1). The interrupt line is 0.
- R2: The output-control register of pin p is at 0x4E44+p. Its bits are: bit 5 direction (1 = output), bit 4 drive type (1 = push-pull, 0 = open-drain), bit 3 pull enable, bits 2:1 pull select, bit 0 output value. These six bits read back as written, and bits 7:6 read 0. Bit 0 drives pad_out[p], bit 3 drives pull_en[p], and bits 2:1 drive pull_sel[2p+1:2p].
- R3: In push-pull mode, pad_oe[p] equals the direction bit. In open-drain mode, pad_oe[p] is the direction bit AND NOT the output value.
- R4: The input-control register of pin p is at 0x4E51+p. Bits 2:1 hold the detection mode and read back as written. Bit 0 reads the pin level two clock edges after pad_in[p] changes. Bits 7:3 read 0, and writes to bit 0 have no effect.
- R5: Detection mode 0 ignores all edges, 1 detects falling edges, 2 detects rising edges and 3 detects both. A detected edge sets the pin's pending bit on the third rising clock edge after the pad change.
- R6: Pending bits for pins 0 to 6 are bits 0 to 6 of the status register at 0x4E0B. Pending bits for pins 7 to 12 are bits 0 to 5 of the status register at 0x4E0C. An edge sets only its own pin's bit.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: The mask registers are at 0x4E19 (group 0) and 0x4E1A (group 1), with the same bit layout as the status registers. A mask bit of 1 suppresses that pin's interrupt, but the pending bit is still set.
- R9: The interrupt line is high exactly while some pending bit is set and its mask bit is 0. It stays high until that bit is cleared or masked.
- R10: If a clearing write to a status bit lands in the same cycle as a new edge on that bit, the bit stays pending. Other bits cleared by the same write still clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Read data for reg_addr |
| pad_in | input | 13 | Pin input levels (asynchronous) |
| pad_out | output | 13 | Value driven per pin |
| pad_oe | output | 13 | Output enable per pin |
| pull_en | output | 13 | Pull resistor enable per pin |
| pull_sel | output | 26 | Two-bit pull selection per pin |
| irq | output | 1 | Combined interrupt toward the host |

## Verification
The bench writes all 64 values of the six control bits on every pin. It checks each output and the open-drain release of the output enable. A design that derived the output enable from direction alone would keep driving a high open-drain pin. Every pin is swept through all four detection modes with both edge directions, and the whole status byte of both groups is compared each time. This catches a wrong group boundary at pin 7, a swapped rising/falling encoding, or a status bit set three cycles too early or too late. A clearing write is timed to land on the exact edge that sets a new pending bit. A design that let the clear win would lose that interrupt, and one that ignored the clear would leave the older bit pending.

// File: rtl/edge_gpio_pkg.sv
package edge_gpio_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_mode_e;

    // Output-control register, bit 5 down to bit 0
    typedef struct packed {
        logic       dir_out;
        logic       push_pull;
        logic       pull_on;
        logic [1:0] pull_kind;
        logic       value;
    } out_ctrl_t;

    function automatic logic edge_hit(input edge_mode_e mode,
                                      input logic cur, input logic prev);
        case (mode)
            EDGE_FALL: return prev & ~cur;
            EDGE_RISE: return cur & ~prev;
            EDGE_ANY:  return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic drive_enable(input out_ctrl_t c);
        return c.dir_out & (c.push_pull | ~c.value);
    endfunction

endpackage

// File: rtl/edge_gpio_pin.sv
module edge_gpio_pin
    import edge_gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       out_we,
    input  logic       in_we,
    input  out_ctrl_t  wr_ctrl,
    input  logic [1:0] wr_mode,
    input  logic       pad_in,
    output out_ctrl_t  ctrl,
    output logic [1:0] mode,
    output logic       level,
    output logic       edge_ev,
    output logic       pad_out,
    output logic       pad_oe,
    output logic       pull_en,
    output logic [1:0] pull_sel
);
    out_ctrl_t  ctrl_q;
    edge_mode_e mode_q;
    logic       sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            mode_q  <= EDGE_OFF;
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            if (out_we) ctrl_q <= wr_ctrl;
            if (in_we)  mode_q <= edge_mode_e'(wr_mode);
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign ctrl     = ctrl_q;
    assign mode     = mode_q;
    assign level    = sync2_q;
    assign edge_ev  = edge_hit(mode_q, sync2_q, prev_q);
    assign pad_out  = ctrl_q.value;
    assign pad_oe   = drive_enable(ctrl_q);
    assign pull_en  = ctrl_q.pull_on;
    assign pull_sel = ctrl_q.pull_kind;

    // R3
    od_release_chk: assert property (@(posedge clk) disable iff (rst)
        (out_we && !wr_ctrl.push_pull && wr_ctrl.value) |=> !pad_oe);

    // R5
    no_edge_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> !edge_ev);

endmodule

// File: rtl/edge_gpio_irq.sv
module edge_gpio_irq #(
    parameter int NPINS   = 13,
    parameter int G0_PINS = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPINS-1:0]   ev,
    input  logic [1:0]         st_we,
    input  logic [1:0]         mk_we,
    input  logic [G0_PINS-1:0] wdata,
    output logic [NPINS-1:0]   status,
    output logic [NPINS-1:0]   mask,
    output logic               irq
);
    logic [NPINS-1:0] clr, mwe, mval;

    for (genvar i = 0; i < NPINS; i++) begin : g_bit
        if (i < G0_PINS) begin : g_grp0
            assign clr[i]  = st_we[0] & wdata[i];
            assign mwe[i]  = mk_we[0];
            assign mval[i] = wdata[i];
        end else begin : g_grp1
            assign clr[i]  = st_we[1] & wdata[i-G0_PINS];
            assign mwe[i]  = mk_we[1];
            assign mval[i] = wdata[i-G0_PINS];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~clr) | ev;
            mask   <= (mask & ~mwe) | (mval & mwe);
        end
    end

    assign irq = |(status & ~mask);

    // R5
    event_sets_status_chk: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev)));

    // R7
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (st_we[0] && wdata[0] && !ev[0]) |=> !status[0]);

    // R1
    mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask == '1));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && st_we == 2'b00 && mk_we == 2'b00) |=> irq);

endmodule

// File: rtl/edge_gpio_ctrl.sv
module edge_gpio_ctrl
    import edge_gpio_pkg::*;
#(
    parameter int NPINS   = 13,
    parameter int G0_PINS = 7,
    parameter int ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] OUT_BASE  = 'h4E44,
    parameter logic [ADDR_W-1:0] IN_BASE   = 'h4E51,
    parameter logic [ADDR_W-1:0] STAT_BASE = 'h4E0B,
    parameter logic [ADDR_W-1:0] MASK_BASE = 'h4E19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic               reg_we,
    output logic [7:0]         reg_rdata,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pull_en,
    output logic [2*NPINS-1:0] pull_sel,
    output logic               irq
);
    localparam int G1_PINS = NPINS - G0_PINS;

    out_ctrl_t        ctrl_q [NPINS];
    logic [1:0]       mode_q [NPINS];
    logic [NPINS-1:0] level, ev, status, mask;
    logic [1:0]       st_we, mk_we;
    logic             unused_wbit;

    assign unused_wbit = reg_wdata[7];

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic out_we, in_we;
        assign out_we = reg_we && (reg_addr == ADDR_W'(OUT_BASE + p));
        assign in_we  = reg_we && (reg_addr == ADDR_W'(IN_BASE + p));

        edge_gpio_pin u_pin (
            .clk      (clk),
            .rst      (rst),
            .out_we   (out_we),
            .in_we    (in_we),
            .wr_ctrl  (out_ctrl_t'(reg_wdata[5:0])),
            .wr_mode  (reg_wdata[2:1]),
            .pad_in   (pad_in[p]),
            .ctrl     (ctrl_q[p]),
            .mode     (mode_q[p]),
            .level    (level[p]),
            .edge_ev  (ev[p]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p]),
            .pull_en  (pull_en[p]),
            .pull_sel (pull_sel[2*p +: 2])
        );
    end

    for (genvar g = 0; g < 2; g++) begin : g_grp
        assign st_we[g] = reg_we && (reg_addr == ADDR_W'(STAT_BASE + g));
        assign mk_we[g] = reg_we && (reg_addr == ADDR_W'(MASK_BASE + g));
    end

    edge_gpio_irq #(.NPINS(NPINS), .G0_PINS(G0_PINS)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .st_we  (st_we),
        .mk_we  (mk_we),
        .wdata  (reg_wdata[G0_PINS-1:0]),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (reg_addr == ADDR_W'(OUT_BASE + p)) reg_rdata = {2'b00, ctrl_q[p]};
            if (reg_addr == ADDR_W'(IN_BASE + p))  reg_rdata = {5'b0, mode_q[p], level[p]};
        end
        if (reg_addr == STAT_BASE)
            for (int b = 0; b < G0_PINS; b++) reg_rdata[b] = status[b];
        if (reg_addr == ADDR_W'(STAT_BASE + 1))
            for (int b = 0; b < G1_PINS; b++) reg_rdata[b] = status[G0_PINS+b];
        if (reg_addr == MASK_BASE)
            for (int b = 0; b < G0_PINS; b++) reg_rdata[b] = mask[b];
        if (reg_addr == ADDR_W'(MASK_BASE + 1))
            for (int b = 0; b < G1_PINS; b++) reg_rdata[b] = mask[G0_PINS+b];
    end

endmodule

// File: tb/edge_gpio_ctrl_tb_top.sv
module edge_gpio_ctrl_tb_top;
    localparam int N = 13;
    localparam int G0 = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_rdata;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_out, pad_oe, pull_en;
    logic [2*N-1:0] pull_sel;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    edge_gpio_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en),
        .pull_sel(pull_sel), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [15:0] stat_addr(input int p);
        return (p < G0) ? 16'h4E0B : 16'h4E0C;
    endfunction

    function automatic int grp_bit(input int p);
        return (p < G0) ? p : p - G0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int p = 0; p < N; p++) begin
            rd(16'h4E44 + 16'(p), d); chk("R1 out ctrl reset", d, 0);
            rd(16'h4E51 + 16'(p), d); chk("R1 in ctrl reset", d, 0);
        end
        rd(16'h4E0B, d); chk("R1 status0 reset", d, 0);
        rd(16'h4E0C, d); chk("R1 status1 reset", d, 0);
        rd(16'h4E19, d); chk("R1 mask0 reset", d, 8'h7F);
        rd(16'h4E1A, d); chk("R1 mask1 reset", d, 8'h3F);
        chk("R1 irq reset", irq, 0);

        // R2, R3: exhaustive output-control sweep
        for (int p = 0; p < N; p++) begin
            for (int v = 0; v < 64; v++) begin
                logic [5:0] b;
                b = 6'(v);
                wr(16'h4E44 + 16'(p), {2'b11, b});
                rd(16'h4E44 + 16'(p), d);
                chk("R2 out ctrl readback", d, {2'b00, b});
                chk("R2 pad_out", pad_out[p], b[0]);
                chk("R2 pull_en", pull_en[p], b[3]);
                chk("R2 pull_sel", pull_sel[2*p +: 2], b[2:1]);
                chk("R3 pad_oe", pad_oe[p], b[5] & (b[4] | ~b[0]));
            end
            wr(16'h4E44 + 16'(p), 8'h00);
        end

        // R4: mode readback, level sync, ignored bits
        for (int p = 0; p < N; p++) begin
            wr(16'h4E51 + 16'(p), 8'hFE);
            rd(16'h4E51 + 16'(p), d);
            chk("R4 mode readback level low", d, 8'h06);
            pad_in[p] = 1'b1;
            @(posedge clk); @(negedge clk);
            rd(16'h4E51 + 16'(p), d);
            chk("R4 level after one edge", d, 8'h06);
            wait_edges(1);
            rd(16'h4E51 + 16'(p), d);
            chk("R4 level after two edges", d, 8'h07);
            wr(16'h4E51 + 16'(p), 8'h01);
            rd(16'h4E51 + 16'(p), d);
            chk("R4 bit0 write ignored", d, 8'h01);
            pad_in[p] = 1'b0;
            wait_edges(3);
            wr(16'h4E0B, 8'hFF);
            wr(16'h4E0C, 8'hFF);
        end

        // R5, R6: every pin, every mode, both edges (masked)
        for (int p = 0; p < N; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic [7:0] expb;
                expb = 8'(1 << grp_bit(p));
                wr(16'h4E51 + 16'(p), 8'(m << 1));
                pad_in[p] = 1'b1;
                wait_edges(2);
                rd(stat_addr(p), d);
                chk("R5 no status before third edge", d, 0);
                wait_edges(1);
                rd(stat_addr(p), d);
                chk("R5 R6 rising edge status", d, (m[1]) ? expb : 8'h00);
                rd((p < G0) ? 16'h4E0C : 16'h4E0B, d2);
                chk("R6 other group untouched", d2, 0);
                chk("R8 masked irq low", irq, 0);
                wr(stat_addr(p), 8'hFF);
                pad_in[p] = 1'b0;
                wait_edges(3);
                rd(stat_addr(p), d);
                chk("R5 R6 falling edge status", d, (m[0]) ? expb : 8'h00);
                wr(stat_addr(p), 8'hFF);
                rd(stat_addr(p), d);
                chk("R7 cleared", d, 0);
            end
            wr(16'h4E51 + 16'(p), 8'h00);
        end

        // R7, R8, R9: mask and interrupt on pin 9 (group 1 bit 2)
        wr(16'h4E51 + 16'd9, 8'h04);
        wr(16'h4E1A, 8'h3B);
        rd(16'h4E1A, d); chk("R8 mask readback", d, 8'h3B);
        pad_in[9] = 1'b1;
        wait_edges(3);
        chk("R9 irq on unmasked pending", irq, 1);
        wait_edges(5);
        chk("R9 irq held", irq, 1);
        wr(16'h4E0C, 8'hFB);
        rd(16'h4E0C, d); chk("R7 write zero keeps bit", d, 8'h04);
        chk("R9 irq still high", irq, 1);
        wr(16'h4E1A, 8'h3F);
        chk("R8 irq masked", irq, 0);
        rd(16'h4E0C, d); chk("R8 status kept while masked", d, 8'h04);
        wr(16'h4E1A, 8'h3B);
        chk("R9 irq after unmask", irq, 1);
        wr(16'h4E0C, 8'h04);
        chk("R9 irq after clear", irq, 0);
        rd(16'h4E0C, d); chk("R7 bit cleared", d, 0);

        // R10: clear and new edge in the same cycle
        wr(16'h4E51 + 16'd3, 8'h04);
        wr(16'h4E51 + 16'd2, 8'h06);
        pad_in[3] = 1'b1;
        wait_edges(3);
        rd(16'h4E0B, d); chk("R10 setup pending", d, 8'h08);
        pad_in[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        reg_addr = 16'h4E0B; reg_wdata = 8'hFF; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
        rd(16'h4E0B, d); chk("R10 new edge survives clear", d, 8'h04);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule